// File: doc/BRIEF.md
# Nonuniform flash sector geometry decoder

This block describes the erase layout of a parallel NOR flash whose sectors fall into up to four regions. Each region has its own sector count and sector size. The regions are placed back to back from offset zero, in index order. Given a byte offset, the block returns the size of the sector that holds it and that sector's base address. An erase engine uses this pair to clear exactly one sector, whatever region the sector lies in.

After reset the block checks the region configuration, one region per cycle. It works out the chip length and the number of active regions, and flags any configuration it cannot use. If no region is configured, a single uniform count/length pair stands in as region 0. The block also returns the erase-region bytes of a CFI-style query table, one byte per index.

Top module: `sector_geom`

## Requirements
- R1: The regions are laid out contiguously from offset 0 in index order. For an in-range offset, `sec_len` is the sector length of the region that contains the offset, and `lk_valid` is 1.
- R2: The number of active regions is the count of regions before the first region whose sector count is zero. It appears on `region_num`, and the query returns it at index 0x2C.
- R3: A region sector length that is zero, not a power of two, not a multiple of 256, or not below 2^24 sets `cfg_err`.
- R4: If the running total before a region is not a multiple of that region's sector length, `cfg_err` is set.
- R5: If no region is configured (region 0 count is zero), the uniform pair acts as region 0, `region_num` is 1, and `chip_len` is `uni_count*uni_len`. A zero uniform count or an illegal uniform length sets `cfg_err`.
- R6: If regions are configured and the uniform total is nonzero, a uniform total that differs from the regional total sets `cfg_err`.
- R7: `sec_base` is `lk_offset` with the bits below the containing sector's length cleared.
- R8: For region i below `region_num`, the query returns four bytes at indices 0x2D+4i to 0x30+4i, in this order: (count-1)[7:0], (count-1)[15:8], length[15:8], length[23:16]. Any other index (except 0x2C), and any region entry at or beyond `region_num`, returns 0.
- R9: An offset at or beyond `chip_len` sets `out_of_range` and clears `lk_valid`, with `sec_len` and `sec_base` at 0.
- R10: `cfg_done` rises at most NREG+1 clock edges after reset is released and then stays high. While `cfg_done` is 0, or while `cfg_err` is 1, lookups and queries are ignored: `lk_valid`, `out_of_range`, `sec_len`, `sec_base` and `q_byte` are all 0.
- R11: `chip_len` equals the sum over the active regions of count times length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the configuration check |
| cfg_count | input | NREG*CW | Per-region sector counts, region i in bits [i*CW +: CW] |
| cfg_len | input | NREG*AW | Per-region sector lengths in bytes, region i in bits [i*AW +: AW] |
| uni_count | input | CW | Uniform fallback sector count |
| uni_len | input | AW | Uniform fallback sector length |
| lk_offset | input | AW | Byte offset to look up |
| q_index | input | 8 | Query table index |
| cfg_done | output | 1 | Configuration check complete |
| cfg_err | output | 1 | Configuration is unusable |
| region_num | output | clog2(NREG+1) | Number of active regions |
| chip_len | output | AW+CW | Total chip length in bytes |
| lk_valid | output | 1 | Lookup offset lies inside the chip |
| out_of_range | output | 1 | Lookup offset is at or beyond the chip length |
| sec_len | output | AW | Length of the containing sector |
| sec_base | output | AW | Base address of the containing sector |
| q_byte | output | 8 | Query byte at `q_index` |

## Verification
The assertions assume that the configuration inputs hold still from reset release until `cfg_done`, and that they only change again while reset is held. The bench meets this by driving a new geometry only with `rst_n` low and then waiting for `cfg_done`. The lookup and query inputs may change in any cycle, because that path is combinational. The bench changes them on the falling edge and samples on the next falling edge.

// File: rtl/sector_geom.sv
module sector_geom #(
  parameter int NREG = 4,
  parameter int CW   = 16,
  parameter int AW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG*CW-1:0]       cfg_count,
  input  logic [NREG*AW-1:0]       cfg_len,
  input  logic [CW-1:0]            uni_count,
  input  logic [AW-1:0]            uni_len,
  input  logic [AW-1:0]            lk_offset,
  input  logic [7:0]               q_index,
  output logic                     cfg_done,
  output logic                     cfg_err,
  output logic [$clog2(NREG+1)-1:0] region_num,
  output logic [AW+CW-1:0]         chip_len,
  output logic                     lk_valid,
  output logic                     out_of_range,
  output logic [AW-1:0]            sec_len,
  output logic [AW-1:0]            sec_base,
  output logic [7:0]               q_byte
);
  localparam int IW = $clog2(NREG+1);
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int TW = AW + CW;
  localparam logic [7:0] QCNT  = 8'h2C;
  localparam logic [7:0] QBASE = 8'h2D;

  function automatic logic len_ok(input logic [AW-1:0] l);
    return (l != '0) && (l[7:0] == 8'h00) && ((l >> 24) == '0) && ((l & (l - 1'b1)) == '0);
  endfunction

  logic [CW-1:0] rc [NREG];
  logic [AW-1:0] rl [NREG];
  logic [CW-1:0] ec [NREG];
  logic [AW-1:0] el [NREG];
  logic [TW-1:0] bases [NREG+1];

  logic [IW-1:0] idx;
  logic [IW-1:0] nreg;
  logic [TW-1:0] total;
  logic          use_uni;
  logic          done;
  logic          err;

  assign bases[0] = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign rc[i] = cfg_count[i*CW +: CW];
    assign rl[i] = cfg_len[i*AW +: AW];
    if (i == 0) begin : g_first
      assign ec[i] = use_uni ? uni_count : rc[i];
      assign el[i] = use_uni ? uni_len   : rl[i];
    end else begin : g_rest
      assign ec[i] = rc[i];
      assign el[i] = rl[i];
    end
    assign bases[i+1] = bases[i] + TW'(ec[i]) * TW'(el[i]);
  end

  logic [SW-1:0] sel;
  logic          scan_end;
  logic [CW-1:0] cur_cnt;
  logic [AW-1:0] cur_len;
  logic [TW-1:0] uni_total;

  assign sel       = (idx < IW'(NREG)) ? SW'(idx) : '0;
  assign cur_cnt   = rc[sel];
  assign cur_len   = rl[sel];
  assign scan_end  = (idx == IW'(NREG)) || (cur_cnt == '0);
  assign uni_total = TW'(uni_count) * TW'(uni_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      nreg    <= '0;
      total   <= '0;
      use_uni <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else if (!done) begin
      if (scan_end) begin
        done <= 1'b1;
        if (nreg == '0) begin
          use_uni <= 1'b1;
          nreg    <= IW'(1);
          total   <= uni_total;
          if (!len_ok(uni_len) || uni_count == '0) err <= 1'b1;
        end else if (uni_total != '0 && uni_total != total) begin
          err <= 1'b1;
        end
      end else begin
        if (!len_ok(cur_len) || (total & TW'(cur_len - 1'b1)) != '0) err <= 1'b1;
        total <= total + TW'(cur_cnt) * TW'(cur_len);
        nreg  <= nreg + 1'b1;
        idx   <= idx + 1'b1;
      end
    end
  end

  logic          ready;
  logic          hit;
  logic [AW-1:0] hit_len;
  logic [TW-1:0] off_w;

  assign ready = done && !err;
  assign off_w = TW'(lk_offset);

  always_comb begin
    hit     = 1'b0;
    hit_len = '0;
    for (int i = 0; i < NREG; i++) begin
      if (IW'(i) < nreg && off_w >= bases[i] && off_w < bases[i+1]) begin
        hit     = 1'b1;
        hit_len = el[i];
      end
    end
  end

  assign cfg_done     = done;
  assign cfg_err      = err;
  assign region_num   = nreg;
  assign chip_len     = total;
  assign lk_valid     = ready && hit;
  assign out_of_range = ready && !hit;
  assign sec_len      = lk_valid ? hit_len : '0;
  assign sec_base     = lk_valid ? (lk_offset & ~(hit_len - 1'b1)) : '0;

  logic [7:0]    qrel;
  logic [CW-1:0] qcm1;
  logic [AW-1:0] qlen;
  logic [7:0]    qreg;

  assign qrel = q_index - QBASE;
  assign qreg = qrel >> 2;

  always_comb begin
    q_byte = 8'h00;
    qcm1   = '0;
    qlen   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (qreg == 8'(i)) begin
        qcm1 = ec[i] - 1'b1;
        qlen = el[i];
      end
    end
    if (ready) begin
      if (q_index == QCNT) begin
        q_byte = 8'(nreg);
      end else if (q_index >= QBASE && qrel < 8'(4*NREG) && qreg < 8'(nreg)) begin
        case (qrel[1:0])
          2'd0:    q_byte = qcm1[7:0];
          2'd1:    q_byte = 8'(qcm1 >> 8);
          2'd2:    q_byte = qlen[15:8];
          default: q_byte = qlen[23:16];
        endcase
      end
    end
  end

  logic [IW:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cyc <= '0;
    else if (!done) cyc <= cyc + 1'b1;
  end

  AST_DONE_BY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> cyc <= (IW+1)'(NREG)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R10
  AST_IDLE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (sec_len == '0 && q_byte == 8'h00 && !lk_valid)); // R10
  AST_REGION_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (nreg >= IW'(1) && nreg <= IW'(NREG))); // R2
  AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones(sec_len) == 1); // R1
  AST_SECTOR_INSIDE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (TW'(sec_base) + TW'(sec_len) <= chip_len)); // R7
  AST_OOR_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (sec_len == '0 && TW'(lk_offset) >= chip_len)); // R9
endmodule

// File: tb/test_sector_geom.sv
module test_sector_geom;
  localparam int NREG = 4;
  localparam int CW = 16;
  localparam int AW = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREG*CW-1:0] cfg_count = '0;
  logic [NREG*AW-1:0] cfg_len = '0;
  logic [CW-1:0] uni_count = '0;
  logic [AW-1:0] uni_len = '0;
  logic [AW-1:0] lk_offset = '0;
  logic [7:0] q_index = '0;
  logic cfg_done, cfg_err, lk_valid, out_of_range;
  logic [2:0] region_num;
  logic [AW+CW-1:0] chip_len;
  logic [AW-1:0] sec_len, sec_base;
  logic [7:0] q_byte;

  int checks = 0;
  int errors = 0;

  sector_geom #(.NREG(NREG), .CW(CW), .AW(AW)) i_sector_geom (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_len(cfg_len),
    .uni_count(uni_count), .uni_len(uni_len), .lk_offset(lk_offset),
    .q_index(q_index), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .region_num(region_num), .chip_len(chip_len), .lk_valid(lk_valid),
    .out_of_range(out_of_range), .sec_len(sec_len), .sec_base(sec_base),
    .q_byte(q_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  // sel (0 top boot, 1 bottom boot), offset, expected length, expected base
  localparam logic [96:0] VEC [15] = '{
    {1'b0, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000},
    {1'b0, 32'h0001_2345, 32'h0001_0000, 32'h0001_0000},
    {1'b0, 32'h007E_FFFF, 32'h0001_0000, 32'h007E_0000},
    {1'b0, 32'h007F_0000, 32'h0000_8000, 32'h007F_0000},
    {1'b0, 32'h007F_7FFF, 32'h0000_8000, 32'h007F_0000},
    {1'b0, 32'h007F_8001, 32'h0000_2000, 32'h007F_8000},
    {1'b0, 32'h007F_A010, 32'h0000_2000, 32'h007F_A000},
    {1'b0, 32'h007F_C000, 32'h0000_4000, 32'h007F_C000},
    {1'b0, 32'h007F_FFFF, 32'h0000_4000, 32'h007F_C000},
    {1'b1, 32'h0000_3FFF, 32'h0000_4000, 32'h0000_0000},
    {1'b1, 32'h0000_4000, 32'h0000_2000, 32'h0000_4000},
    {1'b1, 32'h0000_7FFE, 32'h0000_2000, 32'h0000_6000},
    {1'b1, 32'h0000_8123, 32'h0000_8000, 32'h0000_8000},
    {1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000},
    {1'b1, 32'h007F_FFFF, 32'h0001_0000, 32'h007F_0000}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic configure(input logic [CW-1:0] c0, c1, c2, c3,
                           input logic [AW-1:0] l0, l1, l2, l3,
                           input logic [CW-1:0] uc, input logic [AW-1:0] ul,
                           output int edges);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_count = {c3, c2, c1, c0};
    cfg_len = {l3, l2, l1, l0};
    uni_count = uc;
    uni_len = ul;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    while (!cfg_done && edges < 20) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic top_boot(input logic [CW-1:0] uc, input logic [AW-1:0] ul, output int e);
    configure(127, 1, 2, 1, 32'h10000, 32'h8000, 32'h2000, 32'h4000, uc, ul, e);
  endtask

  task automatic bottom_boot(output int e);
    configure(1, 2, 1, 127, 32'h4000, 32'h2000, 32'h8000, 32'h10000, 0, 0, e);
  endtask

  task automatic look(input logic [AW-1:0] off);
    @(negedge clk);
    lk_offset = off;
    @(negedge clk);
  endtask

  task automatic query(input logic [7:0] qi, input logic [7:0] exp, input string tag);
    @(negedge clk);
    q_index = qi;
    @(negedge clk);
    chk(tag, q_byte, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e;
    int cur;
    cur = -1;
    // R10 reset state
    @(negedge clk);
    chk("R10 done in reset", cfg_done, 0);
    chk("R10 sec_len in reset", sec_len, 0);
    chk("R10 q_byte in reset", q_byte, 0);

    for (int k = 0; k < 15; k++) begin
      if (int'(VEC[k][96]) != cur) begin
        cur = int'(VEC[k][96]);
        if (cur == 0) top_boot(0, 0, e); else bottom_boot(e);
        chk("R10 done edges", (e <= NREG + 1), 1);
        chk("R11 chip_len", chip_len, 64'h80_0000);
        chk("R2 region_num", region_num, 4);
      end
      look(VEC[k][95:64]);
      chk("R1 valid", lk_valid, 1);
      chk("R1 sec_len", sec_len, VEC[k][63:32]);
      chk("R7 sec_base", sec_base, VEC[k][31:0]);
    end

    // R9 out of range, bottom boot still loaded
    look(32'h0080_0000);
    chk("R9 oor", out_of_range, 1);
    chk("R9 valid", lk_valid, 0);
    chk("R9 sec_len", sec_len, 0);
    chk("R9 sec_base", sec_base, 0);

    // R8 / R2 query bytes, top boot
    top_boot(0, 0, e);
    query(8'h2C, 8'h04, "R2 query count");
    query(8'h2D, 8'h7E, "R8 r0 cnt lo");
    query(8'h2E, 8'h00, "R8 r0 cnt hi");
    query(8'h2F, 8'h00, "R8 r0 len mid");
    query(8'h30, 8'h01, "R8 r0 len hi");
    query(8'h31, 8'h00, "R8 r1 cnt lo");
    query(8'h33, 8'h80, "R8 r1 len mid");
    query(8'h35, 8'h01, "R8 r2 cnt lo");
    query(8'h37, 8'h20, "R8 r2 len mid");
    query(8'h3B, 8'h40, "R8 r3 len mid");
    query(8'h3D, 8'h00, "R8 beyond table");
    query(8'h10, 8'h00, "R8 other index");

    // R6 matching uniform total is accepted, mismatch is rejected
    top_boot(128, 32'h10000, e);
    chk("R6 match no err", cfg_err, 0);
    top_boot(64, 32'h10000, e);
    chk("R6 mismatch err", cfg_err, 1);
    look(32'h0000_1000);
    chk("R10 lookup ignored on err", lk_valid, 0);
    chk("R10 oor ignored on err", out_of_range, 0);
    query(8'h2C, 8'h00, "R10 query ignored on err");

    // R5 uniform fallback
    configure(0, 0, 0, 0, 0, 0, 0, 0, 128, 32'h10000, e);
    chk("R5 no err", cfg_err, 0);
    chk("R5 region_num", region_num, 1);
    chk("R5 chip_len", chip_len, 64'h80_0000);
    look(32'h0012_3456);
    chk("R5 sec_len", sec_len, 32'h10000);
    chk("R7 uniform base", sec_base, 32'h0012_0000);
    query(8'h2D, 8'h7F, "R5 query cnt lo");
    query(8'h30, 8'h01, "R5 query len hi");
    query(8'h31, 8'h00, "R8 unused region");
    configure(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h10000, e);
    chk("R5 zero uniform count err", cfg_err, 1);

    // R2 list ends at first zero count
    configure(3, 0, 5, 5, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 0, 0, e);
    chk("R2 early end err", cfg_err, 0);
    chk("R2 early end count", region_num, 1);
    chk("R11 early end len", chip_len, 64'h3000);
    chk("R10 early done", (e <= 2), 1);
    look(32'h0000_3000);
    chk("R9 oor after early end", out_of_range, 1);

    // R3 illegal lengths
    configure(1, 0, 0, 0, 32'h3000, 0, 0, 0, 0, 0, e);
    chk("R3 non pow2", cfg_err, 1);
    configure(1, 0, 0, 0, 32'h80, 0, 0, 0, 0, 0, e);
    chk("R3 below 256", cfg_err, 1);
    configure(1, 0, 0, 0, 32'h100_0000, 0, 0, 0, 0, 0, e);
    chk("R3 too large", cfg_err, 1);
    configure(2, 0, 0, 0, 32'h100, 0, 0, 0, 0, 0, e);
    chk("R3 256 legal", cfg_err, 0);

    // R4 misaligned region start
    configure(1, 1, 0, 0, 32'h2000, 32'h4000, 0, 0, 0, 0, e);
    chk("R4 misaligned", cfg_err, 1);
    configure(2, 1, 0, 0, 32'h2000, 32'h4000, 0, 0, 0, 0, e);
    chk("R4 aligned", cfg_err, 0);
    look(32'h0000_5000);
    chk("R1 second region", sec_len, 32'h4000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule